// File: doc/BRIEF.md
# Four-channel daisy-chain interrupt controller

This block arbitrates interrupt requests from four counter channels and presents them to a processor on a daisy-chained interrupt bus. A channel sends a one-cycle request pulse when its count reaches zero. If that channel's interrupt enable is set, the pulse becomes a pending request. While the upstream enable-in is high and no higher or equal channel of this device is under service, a pending request pulls the active-low interrupt line. In an acknowledge cycle the best pending channel supplies an 8-bit vector. That vector is built from a shared 5-bit base plus the channel number. The channel then moves from the pending set to the in-service set.

While any channel is pending or in service, enable-out is held low, so devices further down the chain cannot interrupt. The block watches the opcode bytes fetched by the processor. After the prefix byte 0xED it releases enable-out, so downstream devices can see the whole return instruction. When 0x4D follows the prefix and enable-in is high, it retires the highest-priority in-service channel.

Bus abstraction: an opcode fetch is a cycle with `m1_ni` low and `iorq_ni` high, held for one clock. An acknowledge is a cycle with both strobes low. The acknowledge takes effect in its first clock.

Top module: `chain_irq_ctrl`

## Requirements
- R1: After reset no channel is pending or in service: `int_no` is 1, `vec_vld_o` is 0 and `ieo_o` equals `iei_i`.
- R2: A `req_i[c]` pulse while `ie_i[c]` is 1 makes channel c pending, and `int_no` goes low on the next cycle when `iei_i` is high. A pulse while `ie_i[c]` is 0 is ignored, so `int_no` and `ieo_o` are unchanged.
- R3: In the first clock of an acknowledge (`m1_ni`=0, `iorq_ni`=0) with `int_no` low, `vec_vld_o` is 1. `vec_o` is then {`vec_base_i`[4:0], channel[1:0], 1'b0} for the lowest-numbered eligible channel. Channel 0 has the highest priority.
- R4: An acknowledged channel leaves the pending set and enters the in-service set. A channel c may request only while no channel of index c or lower is in service, so a higher-priority channel can nest over a lower one.
- R5: Outside a return-prefix window, `ieo_o` is 1 only when `iei_i` is 1 and no channel is pending or in service.
- R6: While `iei_i` is 0, `int_no` is 1 and `ieo_o` is 0. An acknowledge then gives `vec_vld_o` 0 and changes no state.
- R7: After a fetch of 0xED and until the next fetch, pending channels do not hold `ieo_o` low. In that window `ieo_o` = `iei_i` and no channel in service.
- R8: A fetch of 0x4D that directly follows a fetch of 0xED, with `iei_i` high, clears the lowest-numbered in-service channel. Any other second byte, or `iei_i` low, clears nothing.
- R9: Clearing `ie_i[c]` drops any pending request of channel c. Setting the enable again does not restore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel zero-count request pulse |
| ie_i | input | 4 | Per-channel interrupt enable |
| vec_base_i | input | 5 | Shared upper bits of the vector |
| iei_i | input | 1 | Daisy-chain enable in |
| m1_ni | input | 1 | Machine-cycle-one strobe, active low |
| iorq_ni | input | 1 | I/O request strobe, active low |
| op_i | input | 8 | Opcode byte seen during a fetch |
| int_no | output | 1 | Interrupt request, active low |
| ieo_o | output | 1 | Daisy-chain enable out |
| vec_o | output | 8 | Interrupt vector, zero when not valid |
| vec_vld_o | output | 1 | Vector driven in the acknowledge cycle |

## Verification
The hardest state to reach is a channel that is pending while another channel is already in service. Only there do nesting, the prefix window releasing enable-out, and a partial or blocked return sequence become visible. The stimulus first services one channel through an acknowledge, then raises a second request above or below it. It then walks fetch sequences such as ED then 00, ED with enable-in dropped before 4D, and a full ED 4D, and checks enable-out and the interrupt line after each byte.

// File: rtl/chain_irq_pkg.sv
package chain_irq_pkg;
  localparam int VEC_W = 8;
  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RET    = 8'h4D;
endpackage

// File: rtl/irq_prio.sv
// Fixed priority, index 0 wins; one-hot grant.
module irq_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar c = 0; c < N; c++) begin : g_bit
    assign gnt_o[c]  = req_i[c] & ~seen[c];
    assign seen[c+1] = seen[c] | req_i[c];
  end
endmodule

// File: rtl/irq_chan.sv
module irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic take_i,
  input  logic done_i,
  output logic pend_o,
  output logic ins_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      ins_o  <= 1'b0;
    end else begin
      // a new pulse in the acknowledge cycle stays pending
      pend_o <= ((pend_o & ~take_i) | set_i) & en_i;
      ins_o  <= (ins_o | take_i) & ~done_i;
    end
  end
endmodule

// File: rtl/reti_decode.sv
module reti_decode
  import chain_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fetch_i,
  input  logic [7:0] op_i,
  output logic       win_o,
  output logic       hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_o <= 1'b0;
    else if (fetch_i) win_o <= (op_i == OP_PREFIX);
  end

  assign hit_o = fetch_i & win_o & (op_i == OP_RET);
endmodule

// File: rtl/chain_irq_ctrl.sv
module chain_irq_ctrl
  import chain_irq_pkg::*;
#(
  parameter  int NCH    = 4,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BASE_W = VEC_W - 1 - CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH-1:0]    ie_i,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic              iei_i,
  input  logic              m1_ni,
  input  logic              iorq_ni,
  input  logic [7:0]        op_i,
  output logic              int_no,
  output logic              ieo_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_vld_o
);
  logic ack, fetch, ack_q, ack_start;
  logic [NCH-1:0] pend, ins, blk, elig, win_oh, take, done_oh, done;
  logic [NCH:0]   ins_acc;
  logic [CH_W-1:0] win_idx, sel_q, sel;
  logic hold_q, win_any, prefix_win, ret_hit;

  assign ack       = ~m1_ni & ~iorq_ni;
  assign fetch     = ~m1_ni & iorq_ni;
  assign ack_start = ack & ~ack_q;

  // in-service at this channel or above blocks it
  assign ins_acc[0] = 1'b0;
  for (genvar c = 0; c < NCH; c++) begin : g_blk
    assign ins_acc[c+1] = ins_acc[c] | ins[c];
    assign blk[c]       = ins_acc[c+1];
  end

  assign elig   = pend & ~blk & {NCH{iei_i}};
  assign int_no = ~|elig;

  irq_prio #(.N(NCH)) u_win (.req_i(elig), .gnt_o(win_oh));
  irq_prio #(.N(NCH)) u_ret (.req_i(ins),  .gnt_o(done_oh));

  always_comb begin
    win_idx = '0;
    for (int c = 0; c < NCH; c++)
      if (win_oh[c]) win_idx = CH_W'(c);
  end

  assign win_any = |win_oh;
  assign take    = win_oh & {NCH{ack_start}};

  reti_decode u_reti (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fetch_i(fetch),
    .op_i   (op_i),
    .win_o  (prefix_win),
    .hit_o  (ret_hit)
  );

  assign done = done_oh & {NCH{ret_hit & iei_i}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irq_chan u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (req_i[c]),
      .en_i  (ie_i[c]),
      .take_i(take[c]),
      .done_i(done[c]),
      .pend_o(pend[c]),
      .ins_o (ins[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      hold_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      ack_q <= ack;
      if (ack_start) begin
        hold_q <= win_any;
        sel_q  <= win_idx;
      end else if (!ack) begin
        hold_q <= 1'b0;
      end
    end
  end

  // vector stays on the bus for a longer acknowledge
  assign sel       = ack_start ? win_idx : sel_q;
  assign vec_vld_o = ack & (ack_start ? win_any : hold_q);
  assign vec_o     = vec_vld_o ? {vec_base_i, sel, 1'b0} : '0;

  assign ieo_o = iei_i & ~|ins & (prefix_win | ~|pend);
endmodule

// File: rtl/chain_irq_chk.sv
module chain_irq_chk
  import chain_irq_pkg::*;
#(
  parameter  int NCH    = 4,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BASE_W = VEC_W - 1 - CH_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    req_i,
  input logic [NCH-1:0]    ie_i,
  input logic [BASE_W-1:0] vec_base_i,
  input logic              iei_i,
  input logic              m1_ni,
  input logic              iorq_ni,
  input logic              int_no,
  input logic              ieo_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              vec_vld_o
);
  logic ack_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_seen <= 1'b0;
    else         ack_seen <= ~m1_ni & ~iorq_ni;
  end

  // R5
  ieo_needs_iei_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ieo_o |-> iei_i);

  // R3
  vec_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> (vec_o[0] == 1'b0) && (vec_o[VEC_W-1 -: BASE_W] == vec_base_i)
                  && !m1_ni && !iorq_ni);

  // R6
  iei_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iei_i |-> int_no && !ieo_o && !vec_vld_o);

  // R4
  ack_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_ni && !iorq_ni && !ack_seen && !int_no) |=> !ieo_o);

  // R2
  req_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(req_i & ie_i)) && ieo_o && m1_ni) |=> (!int_no || !iei_i));
endmodule

bind chain_irq_ctrl chain_irq_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ie_i      (ie_i),
  .vec_base_i(vec_base_i),
  .iei_i     (iei_i),
  .m1_ni     (m1_ni),
  .iorq_ni   (iorq_ni),
  .int_no    (int_no),
  .ieo_o     (ieo_o),
  .vec_o     (vec_o),
  .vec_vld_o (vec_vld_o)
);

// File: tb/sim_chain_irq_ctrl.sv
`timescale 1ns/1ps
module sim_chain_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req = '0, ie = 4'hF;
  logic [4:0] base = 5'h15;
  logic iei = 1'b1, m1_n = 1'b1, iorq_n = 1'b1;
  logic [7:0] op = '0;
  logic int_n, ieo, vld;
  logic [7:0] vec;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  chain_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ie_i(ie), .vec_base_i(base),
    .iei_i(iei), .m1_ni(m1_n), .iorq_ni(iorq_n), .op_i(op),
    .int_no(int_n), .ieo_o(ieo), .vec_o(vec), .vec_vld_o(vld)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [3:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
    #1;
  endtask

  task automatic do_ack(input string tag, input logic ev, input logic [1:0] ch);
    @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0;
    #1;
    check({tag, " vld"}, {7'd0, vld}, {7'd0, ev});
    check({tag, " vec"}, vec, ev ? {base, ch, 1'b0} : 8'h00);
    @(negedge clk); m1_n = 1'b1; iorq_n = 1'b1;
    #1;
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk); m1_n = 1'b0; op = b;
    @(negedge clk); m1_n = 1'b1; op = '0;
    #1;
  endtask

  task automatic reti();
    fetch(8'hED);
    fetch(8'h4D);
  endtask

  task automatic t_reset();
    check("R1 int", {7'd0, int_n}, 8'd1);
    check("R1 vld", {7'd0, vld}, 8'd0);
    check("R1 ieo", {7'd0, ieo}, 8'd1);
    iei = 1'b0; #1;
    check("R1 ieo follows iei", {7'd0, ieo}, 8'd0);
    iei = 1'b1; #1;
  endtask

  task automatic t_ignore();
    ie = 4'b1011;
    pulse_req(4'b0100);
    check("R2 masked int", {7'd0, int_n}, 8'd1);
    check("R2 masked ieo", {7'd0, ieo}, 8'd1);
    ie = 4'hF;
  endtask

  task automatic t_single();
    pulse_req(4'b0100);
    check("R2 int", {7'd0, int_n}, 8'd0);
    check("R5 ieo pend", {7'd0, ieo}, 8'd0);
    do_ack("R3 ch2", 1'b1, 2'd2);
    check("R4 int after ack", {7'd0, int_n}, 8'd1);
    check("R5 ieo service", {7'd0, ieo}, 8'd0);
    reti();
    check("R8 cleared", {7'd0, ieo}, 8'd1);
  endtask

  task automatic t_priority();
    pulse_req(4'b1010);
    do_ack("R3 ch1 wins", 1'b1, 2'd1);
    check("R4 ch3 blocked", {7'd0, int_n}, 8'd1);
    fetch(8'hED);
    check("R7 service holds ieo", {7'd0, ieo}, 8'd0);
    fetch(8'h4D);
    check("R8 ch3 free", {7'd0, int_n}, 8'd0);
    do_ack("R3 ch3", 1'b1, 2'd3);
    reti();
    check("R8 idle", {7'd0, ieo}, 8'd1);
  endtask

  task automatic t_nest();
    pulse_req(4'b0100);
    do_ack("R3 ch2 first", 1'b1, 2'd2);
    pulse_req(4'b0001);
    check("R4 nest int", {7'd0, int_n}, 8'd0);
    do_ack("R4 nest ch0", 1'b1, 2'd0);
    reti();
    check("R8 ch2 still in service", {7'd0, ieo}, 8'd0);
    reti();
    check("R8 both clear", {7'd0, ieo}, 8'd1);
  endtask

  task automatic t_iei();
    iei = 1'b0;
    pulse_req(4'b0010);
    check("R6 int", {7'd0, int_n}, 8'd1);
    check("R6 ieo", {7'd0, ieo}, 8'd0);
    do_ack("R6 no vec", 1'b0, 2'd0);
    iei = 1'b1; #1;
    check("R6 pend kept", {7'd0, int_n}, 8'd0);
    do_ack("R6 ch1", 1'b1, 2'd1);
    reti();
    check("R6 clean", {7'd0, ieo}, 8'd1);
  endtask

  task automatic t_window();
    pulse_req(4'b0001);
    check("R5 pend ieo", {7'd0, ieo}, 8'd0);
    fetch(8'hED);
    check("R7 window ieo", {7'd0, ieo}, 8'd1);
    check("R7 int held", {7'd0, int_n}, 8'd0);
    fetch(8'h00);
    check("R7 window over", {7'd0, ieo}, 8'd0);
    do_ack("R7 ch0", 1'b1, 2'd0);
    reti();
    check("R7 clean", {7'd0, ieo}, 8'd1);
  endtask

  task automatic t_reti_neg();
    pulse_req(4'b0010);
    do_ack("R8 ch1", 1'b1, 2'd1);
    fetch(8'hED);
    fetch(8'h00);
    check("R8 wrong byte", {7'd0, ieo}, 8'd0);
    fetch(8'h4D);
    check("R8 no prefix", {7'd0, ieo}, 8'd0);
    fetch(8'hED);
    iei = 1'b0;
    fetch(8'h4D);
    iei = 1'b1; #1;
    check("R8 iei low", {7'd0, ieo}, 8'd0);
    reti();
    check("R8 proper", {7'd0, ieo}, 8'd1);
  endtask

  task automatic t_disable();
    pulse_req(4'b1000);
    check("R9 pend", {7'd0, int_n}, 8'd0);
    @(negedge clk); ie[3] = 1'b0;
    @(negedge clk); #1;
    check("R9 drop int", {7'd0, int_n}, 8'd1);
    check("R9 drop ieo", {7'd0, ieo}, 8'd1);
    ie[3] = 1'b1;
    @(negedge clk); #1;
    check("R9 not restored", {7'd0, int_n}, 8'd1);
  endtask

  task automatic t_base();
    base = 5'h0A;
    pulse_req(4'b0001);
    do_ack("R3 base", 1'b1, 2'd0);
    reti();
    base = 5'h15;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_ignore();
    t_single();
    t_priority();
    t_nest();
    t_iei();
    t_window();
    t_reti_neg();
    t_disable();
    t_base();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule